// File: doc/BRIEF.md
# Timer compare-match output unit

This block watches a free-running timer value supplied from outside and turns equality events against two compare values into pin activity. The first compare value drives a bank of six sticky set outputs. Each output rises on a match only when its own enable bit is 1, and it stays high until software clears it. The second compare value drives two toggle flip-flops. Each flip-flop inverts on a match when its external toggle-enable input is high, and its state drives its output pin directly.

A match is an event, not a level. An event fires only on the cycle in which the timer and the compare value first become equal. A timer that parks on the compare value therefore produces a single event. A byte-wide register port gives software write access to the six enable bits. It also returns a live view of those enables and of both flip-flop states. A separate masked clear port lowers set outputs.

Top module: `cmp_match_out`

## Requirements
- R1: A match requires all 16 bits of `timer_val` to equal the compare value. An event fires only in a cycle where they are equal and were not equal in the previous cycle, or in the first cycle after reset. Outputs respond at the clock edge that ends the event cycle. Remaining equal produces no further events.
- R2: After reset, `set_out` is 6'b000000, `tgl_out` is 2'b11 and `reg_rdata` reads 8'hC0.
- R3: An event against `cmp_set_val` raises `set_out[i]` at that edge for every i whose enable bit (`reg_rdata[i]`) was 1 before the edge.
- R4: A set output whose enable bit is 0 never rises. No set output rises without an event against `cmp_set_val`.
- R5: A raised set output holds until a cycle with `clr_en`=1 and `clr_mask[i]`=1 lowers it at the next edge. If that output is set in the same cycle, the set wins.
- R6: A cycle with `reg_wr`=1 loads `reg_wdata[5:0]` into the six enable bits at the next edge. `reg_wdata[7:6]` is ignored and leaves both flip-flops unchanged. An event in the write cycle uses the enables held before the write.
- R7: `reg_rdata` is combinational and reads {`tgl_out[1]`, `tgl_out[0]`, enables[5:0]}, with bit 7 for flip-flop 1 and bit 6 for flip-flop 0.
- R8: An event against `cmp_tgl_val` inverts `tgl_out[j]` at that edge when `tgl_en[j]` is 1. Otherwise `tgl_out[j]` holds.
- R9: The two compare paths are independent. An event against `cmp_set_val` alone never changes `tgl_out`, and an event against `cmp_tgl_val` alone never raises `set_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_val | input | 16 | Current free-running timer value |
| cmp_set_val | input | 16 | Compare value for the set outputs |
| cmp_tgl_val | input | 16 | Compare value for the toggle flip-flops |
| tgl_en | input | 2 | Per-flip-flop toggle enables |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data; bits 5..0 are the enables |
| reg_rdata | output | 8 | Live register read value |
| clr_en | input | 1 | Clear strobe for set outputs |
| clr_mask | input | 6 | Set outputs to clear when `clr_en` is 1 |
| set_out | output | 6 | Sticky set-on-match outputs |
| tgl_out | output | 2 | Toggle flip-flop outputs |

## Verification
A stuck or missed edge-detect flag shows up within one cycle of the timer parking on a compare value. The result is either a second toggle or a set output that comes back after a clear. A wrong enable bit appears at once in `reg_rdata[5:0]`, and it appears at `set_out` on the next set-path event. Flip-flop state is visible both at `tgl_out` and in `reg_rdata[7:6]`. The per-clock model comparison therefore catches a bad toggle on the same edge, and it catches a top-bit write that leaks into the flip-flops one edge after the write.

// File: rtl/cmp_match_pkg.sv
package cmp_match_pkg;
   localparam int unsigned DEF_TMR_W   = 16;
   localparam int unsigned DEF_NUM_SET = 6;
   localparam int unsigned DEF_NUM_TGL = 2;
   localparam int unsigned DEF_REG_W   = 8;

   // events produced by the two compare paths in one cycle
   typedef struct packed {
      logic set_evt;
      logic tgl_evt;
   } match_evt_t;
endpackage

// File: rtl/cmp_edge_det.sv
module cmp_edge_det #(
   parameter int unsigned TMR_W    = 16,
   parameter bit          ONE_SHOT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TMR_W-1:0] timer_val,
   input  logic [TMR_W-1:0] cmp_val,
   output logic             evt
);
   logic eq;

   assign eq = (timer_val == cmp_val);

   generate
      if (ONE_SHOT) begin : g_one_shot
         logic eq_prev;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) eq_prev <= 1'b0;
            else        eq_prev <= eq;
         end
         assign evt = eq & ~eq_prev;
      end else begin : g_level
         assign evt = eq;
      end
   endgenerate
endmodule

// File: rtl/cmp_set_bank.sv
module cmp_set_bank #(
   parameter int unsigned NUM_SET = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               evt,
   input  logic               wr_en,
   input  logic [NUM_SET-1:0] wr_bits,
   input  logic               clr_en,
   input  logic [NUM_SET-1:0] clr_mask,
   output logic [NUM_SET-1:0] en_q,
   output logic [NUM_SET-1:0] set_q
);
   generate
      for (genvar i = 0; i < NUM_SET; i++) begin : g_pin
         logic hit;
         logic wipe;
         assign hit  = evt & en_q[i];
         assign wipe = clr_en & clr_mask[i];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               en_q[i]  <= 1'b0;
               set_q[i] <= 1'b0;
            end else begin
               if (wr_en) en_q[i] <= wr_bits[i];
               if (hit)       set_q[i] <= 1'b1;
               else if (wipe) set_q[i] <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/cmp_tgl_bank.sv
module cmp_tgl_bank #(
   parameter int unsigned NUM_TGL = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               evt,
   input  logic [NUM_TGL-1:0] tgl_en,
   output logic [NUM_TGL-1:0] tgl_q
);
   generate
      for (genvar j = 0; j < NUM_TGL; j++) begin : g_ff
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                tgl_q[j] <= 1'b1;
            else if (evt && tgl_en[j]) tgl_q[j] <= ~tgl_q[j];
         end
      end
   endgenerate
endmodule

// File: rtl/cmp_match_out.sv
module cmp_match_out
   import cmp_match_pkg::*;
#(
   parameter int unsigned TMR_W    = DEF_TMR_W,
   parameter int unsigned NUM_SET  = DEF_NUM_SET,
   parameter int unsigned NUM_TGL  = DEF_NUM_TGL,
   parameter int unsigned REG_W    = DEF_REG_W,
   parameter bit          ONE_SHOT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TMR_W-1:0]   timer_val,
   input  logic [TMR_W-1:0]   cmp_set_val,
   input  logic [TMR_W-1:0]   cmp_tgl_val,
   input  logic [NUM_TGL-1:0] tgl_en,
   input  logic               reg_wr,
   input  logic [REG_W-1:0]   reg_wdata,
   output logic [REG_W-1:0]   reg_rdata,
   input  logic               clr_en,
   input  logic [NUM_SET-1:0] clr_mask,
   output logic [NUM_SET-1:0] set_out,
   output logic [NUM_TGL-1:0] tgl_out
);
   localparam int unsigned USED_W = NUM_SET + NUM_TGL;

   generate
      if (USED_W != REG_W) begin : g_bad_layout
         $error("cmp_match_out: NUM_SET + NUM_TGL must equal REG_W");
      end
      if (TMR_W < 1 || NUM_SET < 1 || NUM_TGL < 1) begin : g_bad_size
         $error("cmp_match_out: widths and counts must be nonzero");
      end
   endgenerate

   match_evt_t         evts;
   logic [NUM_SET-1:0] en_q;

   cmp_edge_det #(.TMR_W(TMR_W), .ONE_SHOT(ONE_SHOT)) u_det_set (
      .clk(clk), .rst_n(rst_n), .timer_val(timer_val),
      .cmp_val(cmp_set_val), .evt(evts.set_evt)
   );

   cmp_edge_det #(.TMR_W(TMR_W), .ONE_SHOT(ONE_SHOT)) u_det_tgl (
      .clk(clk), .rst_n(rst_n), .timer_val(timer_val),
      .cmp_val(cmp_tgl_val), .evt(evts.tgl_evt)
   );

   cmp_set_bank #(.NUM_SET(NUM_SET)) u_set (
      .clk(clk), .rst_n(rst_n), .evt(evts.set_evt),
      .wr_en(reg_wr), .wr_bits(reg_wdata[NUM_SET-1:0]),
      .clr_en(clr_en), .clr_mask(clr_mask),
      .en_q(en_q), .set_q(set_out)
   );

   cmp_tgl_bank #(.NUM_TGL(NUM_TGL)) u_tgl (
      .clk(clk), .rst_n(rst_n), .evt(evts.tgl_evt),
      .tgl_en(tgl_en), .tgl_q(tgl_out)
   );

   // upper bits of the write data have no destination
   assign reg_rdata = {tgl_out, en_q};
endmodule

// File: rtl/cmp_match_out_chk.sv
module cmp_match_out_chk #(
   parameter int unsigned TMR_W   = 16,
   parameter int unsigned NUM_SET = 6,
   parameter int unsigned NUM_TGL = 2,
   parameter int unsigned REG_W   = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [TMR_W-1:0]   timer_val,
   input logic [TMR_W-1:0]   cmp_set_val,
   input logic [TMR_W-1:0]   cmp_tgl_val,
   input logic [NUM_TGL-1:0] tgl_en,
   input logic               reg_wr,
   input logic [REG_W-1:0]   reg_wdata,
   input logic [REG_W-1:0]   reg_rdata,
   input logic               clr_en,
   input logic [NUM_SET-1:0] clr_mask,
   input logic [NUM_SET-1:0] set_out,
   input logic [NUM_TGL-1:0] tgl_out
);
   logic s_eq, t_eq, s_was, t_was, s_ev, t_ev;

   assign s_eq = (timer_val == cmp_set_val);
   assign t_eq = (timer_val == cmp_tgl_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_was <= 1'b0;
         t_was <= 1'b0;
      end else begin
         s_was <= s_eq;
         t_was <= t_eq;
      end
   end

   assign s_ev = s_eq & ~s_was;
   assign t_ev = t_eq & ~t_was;

   p_set_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
      s_ev |=> ((set_out & $past(reg_rdata[NUM_SET-1:0])) == $past(reg_rdata[NUM_SET-1:0])));

   p_no_rise_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((set_out & ~$past(set_out) & ~$past(reg_rdata[NUM_SET-1:0])) == '0));

   p_no_rise_without_evt_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !s_ev |=> ((set_out & ~$past(set_out)) == '0));

   p_clear_lowers_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !s_ev) |=> ((set_out & $past(clr_mask)) == '0));

   p_enable_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> (reg_rdata[NUM_SET-1:0] == $past(reg_wdata[NUM_SET-1:0])));

   p_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      t_ev |=> (tgl_out == ($past(tgl_out) ^ $past(tgl_en))));

   p_toggle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !t_ev |=> $stable(tgl_out));
endmodule

bind cmp_match_out cmp_match_out_chk #(
   .TMR_W(TMR_W), .NUM_SET(NUM_SET), .NUM_TGL(NUM_TGL), .REG_W(REG_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .timer_val(timer_val),
   .cmp_set_val(cmp_set_val), .cmp_tgl_val(cmp_tgl_val), .tgl_en(tgl_en),
   .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
   .clr_en(clr_en), .clr_mask(clr_mask), .set_out(set_out), .tgl_out(tgl_out)
);

// File: tb/cmp_match_out_tb.sv
module cmp_match_out_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] timer_val = 16'h0000;
   logic [15:0] cmp_set_val = 16'h1234;
   logic [15:0] cmp_tgl_val = 16'h4321;
   logic [1:0]  tgl_en = 2'b00;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = 8'h00;
   logic [7:0]  reg_rdata;
   logic        clr_en = 1'b0;
   logic [5:0]  clr_mask = 6'h00;
   logic [5:0]  set_out;
   logic [1:0]  tgl_out;

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    done     = 1'b0;
   bit    run_cmp  = 1'b0;
   string cur_req  = "R2";

   always #10 clk = ~clk;

   cmp_match_out u_dut (
      .clk(clk), .rst_n(rst_n), .timer_val(timer_val),
      .cmp_set_val(cmp_set_val), .cmp_tgl_val(cmp_tgl_val), .tgl_en(tgl_en),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .clr_en(clr_en), .clr_mask(clr_mask), .set_out(set_out), .tgl_out(tgl_out)
   );

   // behavioural reference model
   bit       m_prev_s, m_prev_t;
   bit [5:0] m_en, m_set;
   bit [1:0] m_tgl;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_prev_s <= 0; m_prev_t <= 0; m_en <= 0; m_set <= 0; m_tgl <= 2'b11;
      end else begin
         bit es, et;
         es = (int'(timer_val) == int'(cmp_set_val)) && !m_prev_s;
         et = (int'(timer_val) == int'(cmp_tgl_val)) && !m_prev_t;
         m_prev_s <= (int'(timer_val) == int'(cmp_set_val));
         m_prev_t <= (int'(timer_val) == int'(cmp_tgl_val));
         for (int i = 0; i < 6; i++) begin
            if (es && m_en[i])              m_set[i] <= 1'b1;
            else if (clr_en && clr_mask[i]) m_set[i] <= 1'b0;
         end
         if (reg_wr) m_en <= reg_wdata[5:0];
         for (int j = 0; j < 2; j++)
            if (et && tgl_en[j]) m_tgl[j] <= ~m_tgl[j];
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && run_cmp && !done) begin
         chk(cur_req, "model set_out", {2'b00, set_out}, {2'b00, m_set});
         chk(cur_req, "model tgl_out", {6'b0, tgl_out}, {6'b0, m_tgl});
         chk(cur_req, "model rdata", reg_rdata, {m_tgl, m_en});
      end
   end

   task automatic tick();
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run incomplete, actual timeout expected finish");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      // R2: reset values
      chk("R2", "rdata reset", reg_rdata, 8'hC0);
      chk("R2", "set reset", {2'b0, set_out}, 8'h00);
      chk("R2", "tgl reset", {6'b0, tgl_out}, 8'h03);
      run_cmp = 1'b1;

      // R6/R7: write enables with top bits set, top bits ignored
      cur_req = "R6";
      reg_wr = 1'b1; reg_wdata = 8'h2D;
      tick(); reg_wr = 1'b0;
      chk("R6", "enable write", reg_rdata, 8'hED);
      reg_wr = 1'b1; reg_wdata = 8'h2D ^ 8'hC0;
      tick(); reg_wr = 1'b0;
      chk("R7", "top bits read flip-flops", reg_rdata, 8'hED);
      chk("R6", "flip-flops unchanged", {6'b0, tgl_out}, 8'h03);

      // R1: near miss in the top bit gives no set
      cur_req = "R1";
      timer_val = 16'h1234 ^ 16'h8000;
      tick(); tick();
      chk("R1", "near miss no set", {2'b0, set_out}, 8'h00);

      // R3/R4: event sets enabled pins only
      cur_req = "R3";
      timer_val = 16'h1234;
      tick();
      chk("R3", "set enabled", {2'b0, set_out}, 8'h2D);
      chk("R4", "disabled stay low", {2'b0, set_out & ~6'h2D}, 8'h00);
      chk("R9", "set event no toggle", {6'b0, tgl_out}, 8'h03);

      // R5: clear while timer parked; no re-set
      cur_req = "R5";
      clr_en = 1'b1; clr_mask = 6'h05;
      tick(); clr_en = 1'b0;
      chk("R5", "partial clear", {2'b0, set_out}, 8'h28);
      tick(); tick();
      chk("R1", "parked timer one event", {2'b0, set_out}, 8'h28);

      // R5: set wins over same-cycle clear
      timer_val = 16'h0000; tick();
      timer_val = 16'h1234; clr_en = 1'b1; clr_mask = 6'h3F;
      tick(); clr_en = 1'b0;
      chk("R5", "set beats clear", {2'b0, set_out}, 8'h2D);

      // R8: toggle path
      cur_req = "R8";
      tgl_en = 2'b01; timer_val = 16'h4321;
      tick();
      chk("R8", "toggle ff0", {6'b0, tgl_out}, 8'h02);
      chk("R7", "rdata top bits", reg_rdata, 8'hAD);
      tick(); tick();
      chk("R1", "parked no retoggle", {6'b0, tgl_out}, 8'h02);
      timer_val = 16'h4320; tick();
      tgl_en = 2'b11; timer_val = 16'h4321;
      tick();
      chk("R8", "toggle both", {6'b0, tgl_out}, 8'h01);
      clr_en = 1'b1; clr_mask = 6'h3F; timer_val = 16'h0001;
      tick(); clr_en = 1'b0;
      chk("R9", "toggle event no set", {2'b0, set_out}, 8'h00);
      tgl_en = 2'b00; timer_val = 16'h4321;
      tick();
      chk("R8", "disabled toggles hold", {6'b0, tgl_out}, 8'h01);

      // R6: write in event cycle uses old enables
      cur_req = "R6";
      timer_val = 16'h0000; tick();
      reg_wr = 1'b1; reg_wdata = 8'h12; timer_val = 16'h1234;
      tick(); reg_wr = 1'b0;
      chk("R6", "old enables used", {2'b0, set_out}, 8'h2D);
      chk("R6", "new enables loaded", reg_rdata, 8'h52);

      // random phase against the model
      cur_req = "R1";
      cmp_set_val = 16'h0F0F; cmp_tgl_val = 16'h0F10;
      for (int k = 0; k < 3000; k++) begin
         case ($urandom % 4)
            0: timer_val = 16'h0F0F;
            1: timer_val = 16'h0F10;
            2: timer_val = 16'h0F0E;
            default: timer_val = 16'($urandom);
         endcase
         reg_wr    = ($urandom % 8) == 0;
         reg_wdata = 8'($urandom);
         clr_en    = ($urandom % 4) == 0;
         clr_mask  = 6'($urandom);
         tgl_en    = 2'($urandom);
         tick();
      end
      reg_wr = 1'b0; clr_en = 1'b0;
      tick();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule